// File: doc/BRIEF.md
# Configuration Access Window Sequencer

This block turns a request for a configuration-space access into the register writes that a local-bus-to-PCI bridge needs before and after that access. A request carries a bus number, a combined device/function number and a register offset. From these the block forms the address to present inside the configuration window, and the value for the window's map register. The map value selects the configuration cycle type, and for far slots on bus 0 it also carries the device select bit.

The bridge has two translation windows that may overlap, and the lower-numbered window wins. Window 0 normally covers 256 MB of non-prefetchable memory. To open a configuration window, the block first grows window 0 to 512 MB so that it hides window 1. It then points window 1 at the configuration space and writes the computed map value. While `cfg_go` is high, the consumer performs its access. When the consumer pulses `xfer_done`, the block puts window 1 back to prefetchable memory and only then shrinks window 0 again. It issues one register write per clock and takes no new request until the sequence has finished.

Top module: `cfg_window_seq`

## Requirements
- R1: After reset the block has `req_ready` high and `wr_en`, `cfg_go` and `req_err` low.
- R2: A request with bus 0 and slot (devfn bits 7:3) of 12 or less produces `cfg_addr` = function (devfn bits 2:0) in bits 10:8, plus a single select bit at bit slot+11, plus the offset. Its map value is 16'h000A, which is cycle type 3'b101 in bits 3:1 with the low-address-enable bit 0 clear.
- R3: A request with bus 0 and slot above 12 places no select bit in `cfg_addr`. For slots 13 to 20 it sets bit slot-5 of the map value instead, on top of 16'h000A. Slots above 20 fall beyond the 16-bit map and get no select bit.
- R4: A request with a bus other than 0 produces `cfg_addr` = bus<<16 | devfn<<8, plus the offset, and the map value 16'h000B (the low-address-enable bit is set).
- R5: The open sequence runs on three consecutive cycles after acceptance, in this order:
  - register 0x54 (window 0 base) gets MEM_BASE | size code 9 (512 MB) in bits 7:4 | enable bit 0;
  - register 0x58 (window 1 base) gets CFG_BASE | size code 4 (16 MB) | enable;
  - register 0x62 (window 1 map) gets the map value.
- R6: After the open writes, `cfg_go` stays high with no write until `xfer_done` is sampled high, and `cfg_addr` stays stable throughout.
- R7: The close sequence runs on the three cycles after `xfer_done`, in this order:
  - 0x58 gets PRE_BASE | size code 8 (256 MB) | prefetch bit 3 | enable;
  - 0x62 gets PRE_PCI bits 31:20 placed in bits 15:4 | memory-multiple type 3'b110 in bits 3:1;
  - 0x54 gets MEM_BASE | size code 8 | enable.

  After that, `req_ready` returns high.
- R8: A request whose bus, devfn or offset exceeds 255 (bit 8 set on the 9-bit field) raises `req_err` for exactly one cycle. It makes no register write, and the block stays ready.
- R9: Requests presented while the block is busy are ignored. They change neither the writes nor `cfg_addr`.
- R10: Base-register writes use `wr_size` 2'b10 (32 bits). Map writes use 2'b01 (16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_bus | input | 9 | Bus number (bit 8 marks out of range) |
| req_devfn | input | 9 | Device/function number |
| req_offset | input | 9 | Configuration register offset |
| req_ready | output | 1 | Block idle and accepting |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| cfg_go | output | 1 | Configuration window open; the access may proceed |
| cfg_addr | output | 32 | Address to use inside the configuration window |
| xfer_done | input | 1 | Access finished; restore the windows |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register offset to write |
| wr_data | output | 32 | Write data |
| wr_size | output | 2 | Write width code |

## Verification
The hardest situation to reach is a new request arriving while a sequence is still in flight. At the ports, this looks like a request that the block simply should not see. The bench therefore keeps `req_valid` high with different, legal field values from the moment of acceptance through the last close write. It then checks, cycle by cycle, that every write and `cfg_addr` still belong to the first request. The slot boundaries 12/13 and 20/21 are also driven explicitly, because that is where the select bit moves from the address to the map and then leaves the map altogether.

// File: rtl/cfg_window_seq.sv
module cfg_window_seq #(
  parameter logic [31:0] MEM_BASE = 32'h4000_0000,
  parameter logic [31:0] PRE_BASE = 32'h5000_0000,
  parameter logic [31:0] CFG_BASE = 32'h6100_0000,
  parameter logic [31:0] PRE_PCI  = 32'h1000_0000,
  parameter logic [7:0]  W0_REG   = 8'h54,
  parameter logic [7:0]  W1_REG   = 8'h58,
  parameter logic [7:0]  M1_REG   = 8'h62
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [8:0]  req_bus,
  input  logic [8:0]  req_devfn,
  input  logic [8:0]  req_offset,
  output logic        req_ready,
  output logic        req_err,
  output logic        cfg_go,
  output logic [31:0] cfg_addr,
  input  logic        xfer_done,
  output logic        wr_en,
  output logic [7:0]  wr_addr,
  output logic [31:0] wr_data,
  output logic [1:0]  wr_size
);
  localparam logic [31:0] HI_MASK  = 32'hFFF0_0000;
  localparam logic [31:0] OPEN_W0  = (MEM_BASE & HI_MASK) | 32'h91;
  localparam logic [31:0] OPEN_W1  = (CFG_BASE & HI_MASK) | 32'h41;
  localparam logic [31:0] CLOSE_W1 = (PRE_BASE & HI_MASK) | 32'h89;
  localparam logic [31:0] CLOSE_W0 = (MEM_BASE & HI_MASK) | 32'h81;
  localparam logic [15:0] CLOSE_M1 = (PRE_PCI[31:16] & 16'hFFF0) | 16'h000C;
  localparam logic [1:0]  SZ32 = 2'b10;
  localparam logic [1:0]  SZ16 = 2'b01;

  typedef enum logic [2:0] {IDLE, OPEN0, OPEN1, OPEN2, GO, CLOSE0, CLOSE1, CLOSE2} st_t;
  st_t st;
  logic [15:0] map_q;

  wire [4:0] slot   = req_devfn[7:3];
  wire       bad    = req_bus[8] | req_devfn[8] | req_offset[8];
  wire       type0  = req_bus[7:0] == 8'd0;
  wire       far    = slot > 5'd12;
  wire       accept = req_valid && (st == IDLE);

  wire [31:0] near_sel = far ? 32'd0 : (32'd1 << (slot + 5'd11));
  wire [15:0] far_sel  = (far && slot <= 5'd20) ? (16'd1 << (slot - 5'd5)) : 16'd0;
  wire [31:0] t0_addr  = ({21'd0, req_devfn[2:0], 8'd0} | near_sel) + {23'd0, req_offset};
  wire [31:0] t1_addr  = {8'd0, req_bus[7:0], req_devfn[7:0], 8'd0} + {23'd0, req_offset};
  wire [31:0] nx_addr  = type0 ? t0_addr : t1_addr;
  wire [15:0] nx_map   = type0 ? (far_sel | 16'h000A) : 16'h000B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      req_err  <= 1'b0;
      cfg_addr <= '0;
      map_q    <= '0;
    end else begin
      req_err <= accept && bad;
      case (st)
        IDLE:    if (accept && !bad) begin
                   st       <= OPEN0;
                   cfg_addr <= nx_addr;
                   map_q    <= nx_map;
                 end
        OPEN0:   st <= OPEN1;
        OPEN1:   st <= OPEN2;
        OPEN2:   st <= GO;
        GO:      if (xfer_done) st <= CLOSE0;
        CLOSE0:  st <= CLOSE1;
        CLOSE1:  st <= CLOSE2;
        default: st <= IDLE;
      endcase
    end
  end

  assign req_ready = st == IDLE;
  assign cfg_go    = st == GO;

  always_comb begin
    wr_en   = 1'b1;
    wr_addr = W0_REG;
    wr_data = '0;
    wr_size = SZ32;
    case (st)
      OPEN0:  wr_data = OPEN_W0;
      OPEN1:  begin wr_addr = W1_REG; wr_data = OPEN_W1; end
      OPEN2:  begin wr_addr = M1_REG; wr_data = {16'd0, map_q}; wr_size = SZ16; end
      CLOSE0: begin wr_addr = W1_REG; wr_data = CLOSE_W1; end
      CLOSE1: begin wr_addr = M1_REG; wr_data = {16'd0, CLOSE_M1}; wr_size = SZ16; end
      CLOSE2: wr_data = CLOSE_W0;
      default: begin wr_en = 1'b0; wr_addr = '0; wr_size = '0; end
    endcase
  end

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !wr_en && req_ready);
  assert_go_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_go |-> !wr_en);
  assert_map_before_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_go) |-> $past(wr_en) && $past(wr_addr) == M1_REG);
  assert_close_w1_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_go) |-> wr_en && wr_addr == W1_REG);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$rose(wr_en && wr_addr == W0_REG && !$past(cfg_go))) |-> $stable(cfg_addr));
  assert_open_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad) |=> wr_en && wr_addr == W0_REG && wr_size == SZ32);
endmodule

// File: tb/cfg_window_seq_test.sv
`timescale 1ns/1ps
module cfg_window_seq_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, xfer_done = 0;
  logic [8:0] req_bus = 0, req_devfn = 0, req_offset = 0;
  logic req_ready, req_err, cfg_go, wr_en;
  logic [31:0] cfg_addr, wr_data;
  logic [7:0] wr_addr;
  logic [1:0] wr_size;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_window_seq uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz,
                     input bit go, input bit rdy, input bit err, input string tag);
    chk(wr_en == en, tag, "wr_en", 64'(wr_en), 64'(en));
    if (en) chk({wr_addr, wr_data, wr_size} == {a, d, sz}, tag, "write",
                64'({wr_addr, wr_data, wr_size}), 64'({a, d, sz}));
    chk({cfg_go, req_ready, req_err} == {go, rdy, err}, tag, "go/ready/err",
        64'({cfg_go, req_ready, req_err}), 64'({go, rdy, err}));
  endtask

  function automatic logic [31:0] e_addr(int b, int d, int o);
    int s = d / 8, f = d % 8, a;
    if (b == 0) begin
      a = f * 256;
      if (s <= 12) a += 2 ** (s + 11);
      return 32'(a + o);
    end
    return 32'(b * 65536 + d * 256 + o);
  endfunction

  function automatic logic [31:0] e_map(int b, int d);
    int s = d / 8, m = 10;
    if (b != 0) return 32'd11;
    if (s > 12 && s <= 20) m += 2 ** (s - 5);
    return 32'(m);
  endfunction

  task automatic access(input int b, input int d, input int o, input int hold,
                        input bit junk, input string tag);
    logic [31:0] ea = e_addr(b, d, o);
    logic [31:0] em = e_map(b, d);
    bit illegal = (b > 255) || (d > 255) || (o > 255);
    @(negedge clk);
    req_valid = 1; req_bus = 9'(b); req_devfn = 9'(d); req_offset = 9'(o);
    @(negedge clk);
    if (illegal) begin
      cyc(0, 0, 0, 0, 0, 1, 1, {tag, " R8"});
      req_valid = 0;
      @(negedge clk);
      cyc(0, 0, 0, 0, 0, 1, 0, {tag, " R8"});
      return;
    end
    if (junk) begin req_bus = 9'd3; req_devfn = 9'd17; req_offset = 9'd8; end
    else req_valid = 0;
    cyc(1, 8'h54, 32'h4000_0091, 2'b10, 0, 0, 0, {tag, " R5 R10"});
    @(negedge clk);
    cyc(1, 8'h58, 32'h6100_0041, 2'b10, 0, 0, 0, {tag, " R5"});
    @(negedge clk);
    cyc(1, 8'h62, em, 2'b01, 0, 0, 0, {tag, " R5 R2 R3 R4 R10"});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      cyc(0, 0, 0, 0, 1, 0, 0, {tag, " R6"});
      chk(cfg_addr == ea, {tag, " R2 R3 R4 R9"}, "cfg_addr", 64'(cfg_addr), 64'(ea));
    end
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
    cyc(1, 8'h58, 32'h5000_0089, 2'b10, 0, 0, 0, {tag, " R7"});
    @(negedge clk);
    cyc(1, 8'h62, 32'h0000_100C, 2'b01, 0, 0, 0, {tag, " R7"});
    @(negedge clk);
    cyc(1, 8'h54, 32'h4000_0081, 2'b10, 0, 0, 0, {tag, " R7"});
    req_valid = 0;
    @(negedge clk);
    cyc(0, 0, 0, 0, 0, 1, 0, {tag, " R7 idle"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cyc(0, 0, 0, 0, 0, 1, 0, "R1 in reset");
    rst_n = 1;
    @(negedge clk);
    cyc(0, 0, 0, 0, 0, 1, 0, "R1 after reset");
    access(0, 0, 0, 1, 0, "t0 slot0");
    access(0, 12 * 8 + 7, 252, 2, 0, "t0 slot12");
    access(0, 13 * 8 + 2, 16, 1, 0, "t0 slot13");
    access(0, 20 * 8, 4, 3, 0, "t0 slot20");
    access(0, 21 * 8 + 1, 8, 1, 0, "t0 slot21");
    access(0, 31 * 8 + 7, 255, 1, 0, "t0 slot31");
    access(1, 255, 64, 2, 0, "t1 bus1");
    access(255, 9, 0, 1, 0, "t1 bus255");
    access(0, 0, 256, 1, 0, "bad offset");
    access(256, 0, 0, 1, 0, "bad bus");
    access(0, 300, 0, 1, 0, "bad devfn");
    access(2, 40, 12, 5, 1, "busy junk R9");
    access(0, 5 * 8 + 3, 20, 4, 1, "busy junk t0 R9");
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule